// File: doc/BRIEF.md
# Power-up Serial Memory Streamer

This block produces the autonomous output stream of a 128-byte serial memory after reset. The host does not have to issue commands. A dedicated stream clock times the output. Each rising edge of that clock moves the open-drain data line on by one bit.

The first nine stream edges after reset are only for alignment, and the line stays released during them. From the tenth edge on, every array byte is sent most significant bit first. Each byte is followed by one released null bit. Bytes come from consecutive addresses, and the address wraps from the top of the array back to zero.

The block also monitors the clock of the command-driven two-wire bus. The first falling edge on that clock hands the data line over to command mode for good. Only a reset brings the streamer back. Both clocks are asynchronous to the system clock and are synchronised before use. The array is read through a plain address/data port, and the byte is taken when its first bit goes out.

Top module: `boot_stream_tx`

## Requirements
- R1: After a synchronous reset, `bus_mode_o` is 0, `sda_oe_o` is 0 and `mem_addr_o` equals the start address (parameter, default 0). `sda_oe_o` stays 0 through the first nine rising edges of `stream_clk_i`.
- R2: On the tenth rising stream edge, `sda_oe_o` becomes 1 and `sda_o` carries bit 7 of the byte stored at the start address.
- R3: One bit is presented per rising stream edge, bits 7 down to 0 of the byte, in that order. Falling stream edges change nothing.
- R4: The ninth bit of every frame is a null bit, with `sda_oe_o` = 1 and `sda_o` = 1 (line released).
- R5: `mem_addr_o` advances by one on the edge that sends the null bit. After address 127 it goes to 0.
- R6: An output change caused by a stream edge appears on the third rising system-clock edge after the rise of `stream_clk_i`, and not on the second.
- R7: A falling edge on `bus_clk_i` sets `bus_mode_o` to 1, `sda_oe_o` to 0 and `sda_o` to 1 on the third system-clock edge after the fall. A bus clock that stays high leaves the stream running.
- R8: Once `bus_mode_o` is 1, it stays 1 until reset. Later stream edges and bus clock edges change neither `sda_oe_o` nor `mem_addr_o`.
- R9: When a stream rise and a bus fall are detected in the same system cycle, the mode change wins. The stream edge is dropped and `mem_addr_o` does not move.
- R10: A reset taken while in command mode restores the state of R1 and restarts the nine-edge alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stream_clk_i | input | 1 | Asynchronous stream clock, one bit per rising edge |
| bus_clk_i | input | 1 | Asynchronous command-bus clock, watched for a falling edge |
| mem_addr_o | output | 7 | Array read address |
| mem_data_i | input | 8 | Array read data for `mem_addr_o` |
| sda_oe_o | output | 1 | 1 while the streamer owns the data line |
| sda_o | output | 1 | Value presented on the data line (1 = released) |
| bus_mode_o | output | 1 | 1 once control has passed to command mode |

## Verification
A stream-clock rise and a bus-clock fall can be detected in the same system cycle. The bench provokes this by moving both inputs on the same system-clock falling edge in the middle of a byte. It then expects command mode three cycles later, the line released, and the address unchanged, because the stream edge must be dropped. A behavioural model runs beside the design and applies the bus event before the stream event on every clock. It is compared with all outputs every cycle, including the cycles in which single stream or bus edges are still working through the synchronisers.

// File: rtl/boot_stream_pkg.sv
package boot_stream_pkg;

    typedef enum logic [1:0] {
        PH_ALIGN = 2'd0,
        PH_FRAME = 2'd1,
        PH_HALT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pad_t;

    localparam logic LINE_RELEASED = 1'b1;

    localparam pad_t PAD_IDLE = '{oe: 1'b0, val: LINE_RELEASED};

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bst_edge_sync.sv
module bst_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic IDLE    = 1'b0,
    parameter bit   FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_tap
        if (g == 0) begin : g_first
            assign chain_d[g] = async_i;
        end else begin : g_rest
            assign chain_d[g] = chain_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE}};
            last_q  <= IDLE;
        end else begin
            chain_q <= chain_d;
            last_q  <= chain_q[STAGES-1];
        end
    end

    if (FALLING) begin : g_fall
        assign edge_o = last_q & ~chain_q[STAGES-1];
    end else begin : g_rise
        assign edge_o = ~last_q & chain_q[STAGES-1];
    end

endmodule

// File: rtl/bst_frame_seq.sv
module bst_frame_seq
    import boot_stream_pkg::*;
#(
    parameter int DEPTH      = 128,
    parameter int DATA_W     = 8,
    parameter int SYNC_EDGES = 9,
    parameter int START_ADDR = 0,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              halt_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [AW-1:0]     mem_addr_o,
    output logic              sda_oe_o,
    output logic              sda_o
);
    localparam int MAXC = max_of(SYNC_EDGES, DATA_W + 1);
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic [DATA_W-2:0] shreg;
    } seq_t;

    seq_t          st_q;
    pad_t          pad_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_next;

    assign addr_next = (addr_q == AW'(DEPTH - 1)) ? '0 : addr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_ALIGN;
            st_q.cnt   <= '0;
            st_q.shreg <= '0;
            pad_q      <= PAD_IDLE;
            addr_q     <= AW'(START_ADDR);
        end else if (halt_i) begin
            st_q.phase <= PH_HALT;
            pad_q      <= PAD_IDLE;
        end else if (step_i) begin
            case (st_q.phase)
                PH_ALIGN: begin
                    if (st_q.cnt == CW'(SYNC_EDGES - 1)) begin
                        st_q.phase <= PH_FRAME;
                        st_q.cnt   <= '0;
                    end else begin
                        st_q.cnt <= st_q.cnt + 1'b1;
                    end
                end
                PH_FRAME: begin
                    if (st_q.cnt == '0) begin
                        pad_q      <= '{oe: 1'b1, val: mem_data_i[DATA_W-1]};
                        st_q.shreg <= mem_data_i[DATA_W-2:0];
                        st_q.cnt   <= st_q.cnt + 1'b1;
                    end else if (st_q.cnt < CW'(DATA_W)) begin
                        pad_q      <= '{oe: 1'b1, val: st_q.shreg[DATA_W-2]};
                        st_q.shreg <= {st_q.shreg[DATA_W-3:0], 1'b0};
                        st_q.cnt   <= st_q.cnt + 1'b1;
                    end else begin
                        pad_q    <= '{oe: 1'b1, val: LINE_RELEASED};
                        st_q.cnt <= '0;
                        addr_q   <= addr_next;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_addr_o = addr_q;
    assign sda_oe_o   = pad_q.oe;
    assign sda_o      = pad_q.val;

    assert_align_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_ALIGN) |-> !sda_oe_o);

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(addr_q)) |->
        (addr_q == (($past(addr_q) == AW'(DEPTH - 1)) ? '0 : $past(addr_q) + 1'b1)));

    assert_halt_released_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_HALT) |-> (!sda_oe_o && sda_o));

endmodule

// File: rtl/boot_stream_tx.sv
module boot_stream_tx
    import boot_stream_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int DATA_W      = 8,
    parameter int SYNC_EDGES  = 9,
    parameter int START_ADDR  = 0,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stream_clk_i,
    input  logic              bus_clk_i,
    output logic [AW-1:0]     mem_addr_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              sda_oe_o,
    output logic              sda_o,
    output logic              bus_mode_o
);
    logic stream_rise;
    logic bus_fall;
    logic mode_q;
    logic halt;

    bst_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0), .FALLING(1'b0)) u_stream_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (stream_clk_i),
        .edge_o  (stream_rise)
    );

    bst_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1), .FALLING(1'b1)) u_bus_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (bus_clk_i),
        .edge_o  (bus_fall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else if (bus_fall) begin
            mode_q <= 1'b1;
        end
    end

    assign halt       = mode_q | bus_fall;
    assign bus_mode_o = mode_q;

    bst_frame_seq #(
        .DEPTH      (DEPTH),
        .DATA_W     (DATA_W),
        .SYNC_EDGES (SYNC_EDGES),
        .START_ADDR (START_ADDR)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .step_i     (stream_rise),
        .halt_i     (halt),
        .mem_data_i (mem_data_i),
        .mem_addr_o (mem_addr_o),
        .sda_oe_o   (sda_oe_o),
        .sda_o      (sda_o)
    );

    assert_mode_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        bus_mode_o |=> bus_mode_o);

    assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_mode_o)) |-> $stable(mem_addr_o));

    assert_no_edge_no_change_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(stream_rise) && !$past(bus_fall)) |->
        ($stable(sda_oe_o) && $stable(sda_o) && $stable(bus_mode_o)));

endmodule

// File: tb/boot_stream_tx_tb_top.sv
`timescale 1ns/1ps
module boot_stream_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stream_clk = 1'b0;
    logic       bus_clk = 1'b1;
    logic [6:0] mem_addr;
    logic [7:0] mem_data;
    logic       sda_oe, sda, bus_mode;

    int tests = 0;
    int fails = 0;
    bit armed = 1'b0;
    bit done  = 1'b0;
    int n_edges = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mv(input logic [6:0] a);
        return ({1'b0, a} * 8'd29) + 8'h5A;
    endfunction

    assign mem_data = mv(mem_addr);

    boot_stream_tx dut_i (
        .clk          (clk),
        .rst          (rst),
        .stream_clk_i (stream_clk),
        .bus_clk_i    (bus_clk),
        .mem_addr_o   (mem_addr),
        .mem_data_i   (mem_data),
        .sda_oe_o     (sda_oe),
        .sda_o        (sda),
        .bus_mode_o   (bus_mode)
    );

    // behavioural reference: each input event takes effect three clocks later
    int       m_align = 9;
    int       m_bit = 0;
    int       m_addr = 0;
    logic     m_oe = 1'b0, m_sda = 1'b1, m_mode = 1'b0;
    logic     last_s = 1'b0, last_b = 1'b1;
    int       cd_s = 0, cd_b = 0;

    always @(posedge clk) begin
        bit fire_s, fire_b;
        fire_s = 1'b0;
        fire_b = 1'b0;
        if (rst) begin
            m_align = 9; m_bit = 0; m_addr = 0;
            m_oe = 1'b0; m_sda = 1'b1; m_mode = 1'b0;
            last_s = 1'b0; last_b = 1'b1; cd_s = 0; cd_b = 0;
        end else begin
            if (stream_clk && !last_s) cd_s = 3;
            last_s = stream_clk;
            if (!bus_clk && last_b) cd_b = 3;
            last_b = bus_clk;
            if (cd_b > 0) begin cd_b--; if (cd_b == 0) fire_b = 1'b1; end
            if (cd_s > 0) begin cd_s--; if (cd_s == 0) fire_s = 1'b1; end
            if (fire_b) begin m_mode = 1'b1; m_oe = 1'b0; m_sda = 1'b1; end
            if (fire_s && !m_mode) begin
                if (m_align > 0) begin
                    m_align--;
                end else if (m_bit < 8) begin
                    m_oe = 1'b1;
                    m_sda = mv(7'(m_addr))[7 - m_bit];
                    m_bit++;
                end else begin
                    m_oe = 1'b1; m_sda = 1'b1; m_bit = 0;
                    m_addr = (m_addr + 1) % 128;
                end
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0h exp %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !rst && !done) begin
            chk(m_mode ? "R7 oe" : (m_align > 0 ? "R1 oe" : "R4 oe"), sda_oe, m_oe);
            chk("R3 sda", sda, m_sda);
            chk("R5 addr", mem_addr, m_addr);
            chk("R8 mode", bus_mode, m_mode);
        end
    end

    task automatic pulse(input int hi, input int lo);
        @(negedge clk) stream_clk = 1'b1;
        repeat (hi) @(negedge clk);
        stream_clk = 1'b0;
        repeat (lo) @(negedge clk);
        n_edges++;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_edges = 0;
        @(negedge clk);
    endtask

    initial begin
        int snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        armed = 1'b1;
        @(negedge clk);
        chk("R1 reset oe", sda_oe, 0);
        chk("R1 reset mode", bus_mode, 0);
        chk("R1 reset addr", mem_addr, 0);

        repeat (9) pulse(4, 4);
        chk("R1 quiet after nine", sda_oe, 0);
        pulse(4, 4);
        chk("R2 first bit oe", sda_oe, 1);
        chk("R2 first bit msb", sda, mv(7'd0)[7]);

        for (int i = 0; n_edges < 1160; i++) pulse(3 + (i % 3), 3 + (i % 4));
        chk("R5 addr before wrap", mem_addr, 127);
        pulse(5, 3);
        chk("R5 addr wrapped", mem_addr, 0);
        chk("R4 null oe", sda_oe, 1);
        chk("R4 null released", sda, 1);
        repeat (4) pulse(3, 5);

        // R9: both events in one cycle
        snap = mem_addr;
        @(negedge clk) begin stream_clk = 1'b1; bus_clk = 1'b0; end
        repeat (4) @(negedge clk);
        chk("R9 mode", bus_mode, 1);
        chk("R9 oe released", sda_oe, 0);
        chk("R9 addr held", mem_addr, snap);
        stream_clk = 1'b0;
        repeat (3) @(negedge clk);
        repeat (12) pulse(3, 3);
        chk("R8 oe stays off", sda_oe, 0);
        chk("R8 addr frozen", mem_addr, snap);
        @(negedge clk) bus_clk = 1'b1;
        repeat (5) @(negedge clk);
        bus_clk = 1'b0;
        repeat (5) @(negedge clk);
        bus_clk = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 mode sticky", bus_mode, 1);

        // R10: reset from command mode
        do_reset();
        chk("R10 mode", bus_mode, 0);
        chk("R10 oe", sda_oe, 0);
        chk("R10 addr", mem_addr, 0);
        repeat (9) pulse(3, 4);
        chk("R10 realigned quiet", sda_oe, 0);

        // R6: latency of the tenth edge
        @(negedge clk) stream_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 not after second edge", sda_oe, 0);
        @(negedge clk);
        chk("R6 after third edge", sda_oe, 1);
        repeat (2) @(negedge clk);
        stream_clk = 1'b0;
        repeat (4) @(negedge clk);
        n_edges++;
        repeat (13) pulse(4, 3);
        chk("R7 still streaming", bus_mode, 0);

        // R7: lone bus fall mid-byte
        snap = mem_addr;
        @(negedge clk) bus_clk = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 mode not yet", bus_mode, 0);
        @(negedge clk);
        chk("R7 mode set", bus_mode, 1);
        chk("R7 oe off", sda_oe, 0);
        chk("R7 sda released", sda, 1);
        repeat (10) pulse(3, 3);
        chk("R8 addr frozen again", mem_addr, snap);
        chk("R8 oe off again", sda_oe, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired got 0 exp 1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule